// File: doc/BRIEF.md
# Serially Configured Clock Fan-Out Gate

This block fans one reference clock out to ten output copies and lets a host on a two-wire serial bus switch each copy on or off. The host addresses the block as a write-only slave and then sends configuration bytes. Each byte completed in a transfer updates the enable bits it carries. Each output tracks the reference clock at the same frequency while it is enabled, and is held low while it is disabled. A separate global output-enable pin floats all ten outputs at once, for example during production test. The high-impedance state is reported as a per-output drive flag.

The serial lines are oversampled in the reference clock domain. That clock must therefore run several times faster than the serial clock. Enable changes are moved into the output gates on the falling edge of the reference clock, so an output never produces a shortened high pulse.

Top module: `smb_clkgate_top`

## Requirements
- R1: A transfer whose first byte after START is the 7-bit address 1101001 (sent MSB first) followed by a write bit of 0 is acknowledged: `sda_pull` is high during the ninth serial clock and changes only while `scl` is low.
- R2: If the address differs, or the read/write bit is 1, no acknowledge is given for the address or for any later byte, and the enables stay unchanged until the next START.
- R3: After an address match, each data byte is shifted in MSB first and acknowledged. Bytes are numbered by arrival order from 0 after every START.
- R4: Data byte 0 bits 3..0 set the enables of outputs 3..0 (bit n to output n). Its bits 7..4 are ignored.
- R5: Data byte 1 bits 7..4 set the enables of outputs 7..4 (bit n to output n). Its bits 3..0 are ignored.
- R6: Data byte 2 bit 7 sets output 9 and bit 6 sets output 8. Its bits 5..0 are ignored. Bytes after byte 2 are acknowledged and change nothing.
- R7: After reset, all ten enable bits are 1.
- R8: While `oe_global` is low, every `out_drive` bit is 0 and every `clk_out` bit is 0. While it is high, every `out_drive` bit is 1.
- R9: With `oe_global` high, an enabled output equals `clk_in` and a disabled output stays low. An enable change takes effect only during a low phase of `clk_in`, so no output changes in the middle of a high phase.
- R10: Each byte is applied as soon as its eighth bit arrives. A STOP part-way through a byte keeps the bytes already completed. A repeated START restarts the byte numbering at 0.
- R11: A STOP returns the slave to idle with `sda_pull` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock to be fanned out; also samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Serial bus clock |
| sda_in | input | 1 | Serial bus data as seen on the wire |
| sda_pull | output | 1 | High to pull the data line low (acknowledge) |
| oe_global | input | 1 | Global output enable; low floats all outputs |
| clk_out | output | 10 | Gated copies of `clk_in` |
| out_drive | output | 10 | Per-output drive flag; 0 means high impedance |

## Verification
Random well-addressed transfers of one to five bytes check that each byte lands only on its own sparse bit positions, and that bytes past the third are acknowledged but have no effect. Transfers with a wrong address or with the read bit set are mixed in; they must get no acknowledge and leave the output mask unchanged, which shows that the address compare is exact. Directed sequences cover the reset mask, a STOP in the middle of a byte, and a repeated START that must restart byte numbering, which separates arrival-order indexing from a free-running counter. While all this runs, every high phase of `clk_in` is checked for output changes, and both levels of the global enable are used.

// File: rtl/smb_clkgate_pkg.sv
`timescale 1ns/1ps
package smb_clkgate_pkg;

    localparam int NUM_OUT = 10;
    localparam int BYTE_IDX_W = 2;
    localparam logic [6:0] SLAVE_ADDR = 7'b1101001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } slv_state_e;

    // Serial line events after synchronisation
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // One completed configuration byte
    typedef struct packed {
        logic                  valid;
        logic [BYTE_IDX_W-1:0] idx;
        logic [7:0]            data;
    } cfg_byte_t;

    // Which configuration byte carries the enable of output o
    function automatic int map_byte(int o);
        if (o < 4) return 0;
        if (o < 8) return 1;
        return 2;
    endfunction

    // Bit position inside that byte
    function automatic int map_bit(int o);
        if (o < 8) return o;
        return o - 2;
    endfunction

endpackage

// File: rtl/smb_line_sampler.sv
`timescale 1ns/1ps
module smb_line_sampler
    import smb_clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;
    logic         scl_c;
    logic         sda_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_raw};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_raw};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    assign scl_c = scl_pipe[TOP];
    assign sda_c = sda_pipe[TOP];

    always_comb begin
        evt.sda      = sda_c;
        evt.scl_rise = scl_c & ~scl_d;
        evt.scl_fall = ~scl_c & scl_d;
        evt.start    = scl_c & scl_d & sda_d & ~sda_c;
        evt.stop     = scl_c & scl_d & ~sda_d & sda_c;
    end

endmodule

// File: rtl/smb_write_slave.sv
`timescale 1ns/1ps
module smb_write_slave
    import smb_clkgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    output cfg_byte_t cfg,
    output logic      sda_pull
);
    slv_state_e            state;
    logic [2:0]            bit_cnt;
    logic [7:0]            shreg;
    logic [7:0]            full;
    logic [BYTE_IDX_W-1:0] idx;
    logic                  ack_on;

    assign full     = {shreg[6:0], evt.sda};
    assign sda_pull = ack_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            idx       <= '0;
            ack_on    <= 1'b0;
            cfg.valid <= 1'b0;
            cfg.idx   <= '0;
            cfg.data  <= '0;
        end else begin
            cfg.valid <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                idx     <= '0;
                ack_on  <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                ack_on <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg   <= full;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                if (full[7:1] == SLAVE_ADDR && !full[0])
                                    state <= ST_ADDR_ACK;
                                else
                                    state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (evt.scl_fall) begin
                            if (!ack_on) begin
                                ack_on <= 1'b1;
                            end else begin
                                ack_on  <= 1'b0;
                                state   <= ST_DATA;
                                bit_cnt <= '0;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (evt.scl_rise) begin
                            shreg   <= full;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                cfg.valid <= 1'b1;
                                cfg.idx   <= idx;
                                cfg.data  <= full;
                                if (idx != {BYTE_IDX_W{1'b1}})
                                    idx <= idx + 1'b1;
                                state <= ST_DATA_ACK;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_enable_bank.sv
`timescale 1ns/1ps
module smb_enable_bank
    import smb_clkgate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_byte_t          cfg,
    output logic [NUM_OUT-1:0] en_cfg
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_bit
        localparam int BYTE_POS = map_byte(g);
        localparam int BIT_POS  = map_bit(g);

        always_ff @(posedge clk) begin
            if (rst)
                en_cfg[g] <= 1'b1;
            else if (cfg.valid && cfg.idx == BYTE_IDX_W'(BYTE_POS))
                en_cfg[g] <= cfg.data[BIT_POS];
        end
    end

endmodule

// File: rtl/smb_gate_cell.sv
`timescale 1ns/1ps
module smb_gate_cell (
    input  logic clk_in,
    input  logic rst,
    input  logic en_req,
    input  logic oe,
    output logic clk_out,
    output logic drive,
    output logic gate_q
);
    // Updated on the falling edge, so it only moves during a low phase
    always_ff @(negedge clk_in) begin
        if (rst)
            gate_q <= 1'b1;
        else
            gate_q <= en_req;
    end

    assign drive   = oe;
    assign clk_out = oe & gate_q & clk_in;

endmodule

// File: rtl/smb_clkgate_top.sv
`timescale 1ns/1ps
module smb_clkgate_top
    import smb_clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_in,
    input  logic               rst,
    input  logic               scl,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               oe_global,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] out_drive
);
    bus_evt_t           evt;
    cfg_byte_t          cfg_b;
    logic [NUM_OUT-1:0] en_cfg;
    logic [NUM_OUT-1:0] gate_live;

    smb_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk_in),
        .rst     (rst),
        .scl_raw (scl),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    smb_write_slave u_slave (
        .clk      (clk_in),
        .rst      (rst),
        .evt      (evt),
        .cfg      (cfg_b),
        .sda_pull (sda_pull)
    );

    smb_enable_bank u_bank (
        .clk    (clk_in),
        .rst    (rst),
        .cfg    (cfg_b),
        .en_cfg (en_cfg)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        smb_gate_cell u_gate (
            .clk_in  (clk_in),
            .rst     (rst),
            .en_req  (en_cfg[g]),
            .oe      (oe_global),
            .clk_out (clk_out[g]),
            .drive   (out_drive[g]),
            .gate_q  (gate_live[g])
        );
    end

endmodule

// File: rtl/smb_clkgate_chk.sv
`timescale 1ns/1ps
module smb_clkgate_chk
    import smb_clkgate_pkg::*;
(
    input logic                  clk_in,
    input logic                  rst,
    input logic                  scl,
    input logic                  oe_global,
    input logic                  sda_pull,
    input logic [NUM_OUT-1:0]    clk_out,
    input logic [NUM_OUT-1:0]    out_drive,
    input logic [NUM_OUT-1:0]    en_cfg,
    input logic [NUM_OUT-1:0]    gate_live,
    input logic                  cfg_valid,
    input logic [BYTE_IDX_W-1:0] cfg_idx
);
    AST_DEFAULT_ON: assert property (@(posedge clk_in) disable iff (rst)
        $past(rst) |-> (&en_cfg)); // R7

    AST_OE_FLOAT: assert property (@(posedge clk_in) disable iff (rst)
        !oe_global |-> (out_drive == '0 && clk_out == '0)); // R8

    AST_PULL_SCL_LOW: assert property (@(posedge clk_in) disable iff (rst)
        $rose(sda_pull) |-> !scl); // R1

    AST_EXTRA_DISCARD: assert property (@(posedge clk_in) disable iff (rst)
        (cfg_valid && cfg_idx == {BYTE_IDX_W{1'b1}}) |=> $stable(en_cfg)); // R6

    AST_GATE_FOLLOW: assert property (@(negedge clk_in) disable iff (rst)
        oe_global |-> (clk_out == gate_live)); // R9

endmodule

bind smb_clkgate_top smb_clkgate_chk u_chk (
    .clk_in    (clk_in),
    .rst       (rst),
    .scl       (scl),
    .oe_global (oe_global),
    .sda_pull  (sda_pull),
    .clk_out   (clk_out),
    .out_drive (out_drive),
    .en_cfg    (en_cfg),
    .gate_live (gate_live),
    .cfg_valid (cfg_b.valid),
    .cfg_idx   (cfg_b.idx)
);

// File: tb/smb_clkgate_top_test.sv
`timescale 1ns/1ps
module smb_clkgate_top_test;

    localparam int Q = 6;
    localparam logic [6:0] ADDR = 7'b1101001;

    logic       clk_in = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic       oe_global = 1'b1;
    logic [9:0] clk_out;
    logic [9:0] out_drive;

    int vectors = 0;
    int miscompares = 0;
    logic [9:0] exp_en = 10'h3FF;

    assign sda_line = sda_m & ~sda_pull;

    smb_clkgate_top uut (
        .clk_in    (clk_in),
        .rst       (rst),
        .scl       (scl),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .oe_global (oe_global),
        .clk_out   (clk_out),
        .out_drive (out_drive)
    );

    always #5 clk_in = ~clk_in;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected-mask model from the byte map of R4..R6
    function automatic logic [9:0] apply_byte(logic [9:0] e, int idx, logic [7:0] d);
        logic [9:0] r = e;
        case (idx)
            0: r[3:0] = d[3:0];
            1: r[7:4] = d[7:4];
            2: begin r[9] = d[7]; r[8] = d[6]; end
            default: ;
        endcase
        return r;
    endfunction

    task automatic wq(input int n);
        repeat (n) @(posedge clk_in);
        #1;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b;  wq(Q);
        scl = 1'b1; wq(2 * Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = sda_pull;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic check_outs(input string req);
        @(posedge clk_in); #2;
        chk({req, " R9 high phase"}, {22'd0, clk_out}, {22'd0, oe_global ? exp_en : 10'h000});
        chk("R8 drive flags", {22'd0, out_drive}, {22'd0, {10{oe_global}}});
        #5;
        chk({req, " R9 low phase"}, {22'd0, clk_out}, 32'd0);
    endtask

    task automatic set_oe(input logic v);
        @(negedge clk_in); #1;
        oe_global = v;
    endtask

    // No output may change inside a high phase of clk_in (R9)
    always @(posedge clk_in) begin
        logic [9:0] a;
        if (!rst) begin
            #2 a = clk_out;
            #2 chk("R9 stable high phase", {22'd0, clk_out}, {22'd0, a});
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        logic [6:0] a;
        int kind;
        int nb;
        void'($urandom(32'd24601));
        wq(5);
        rst = 1'b0;
        wq(3);

        // R7: reset mask
        check_outs("R7 reset mask");
        chk("R11 idle release", {31'd0, sda_pull}, 32'd0);

        // R4: byte 0 upper nibble ignored
        bus_start();
        bus_byte({ADDR, 1'b0}, ack); chk("R1 address ack", {31'd0, ack}, 32'd1);
        bus_byte(8'hF5, ack); chk("R3 byte ack", {31'd0, ack}, 32'd1);
        exp_en = apply_byte(exp_en, 0, 8'hF5);
        bus_byte(8'h0F, ack); chk("R5 byte ack", {31'd0, ack}, 32'd1);
        exp_en = apply_byte(exp_en, 1, 8'h0F);
        bus_byte(8'h3F, ack); chk("R6 byte ack", {31'd0, ack}, 32'd1);
        exp_en = apply_byte(exp_en, 2, 8'h3F);
        bus_byte(8'hFF, ack); chk("R6 extra byte ack", {31'd0, ack}, 32'd1);
        bus_stop();
        chk("R11 release after stop", {31'd0, sda_pull}, 32'd0);
        check_outs("R4 R5 R6 sparse map");

        // R10: STOP in the middle of byte 1 keeps byte 0
        bus_start();
        bus_byte({ADDR, 1'b0}, ack); chk("R1 address ack", {31'd0, ack}, 32'd1);
        bus_byte(8'h0A, ack);
        exp_en = apply_byte(exp_en, 0, 8'h0A);
        bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
        bus_stop();
        check_outs("R10 partial byte");

        // R10: repeated START restarts numbering
        bus_start();
        bus_byte({ADDR, 1'b0}, ack);
        bus_byte(8'h03, ack); exp_en = apply_byte(exp_en, 0, 8'h03);
        bus_byte(8'hA0, ack); exp_en = apply_byte(exp_en, 1, 8'hA0);
        bus_start();
        bus_byte({ADDR, 1'b0}, ack); chk("R10 re-address ack", {31'd0, ack}, 32'd1);
        bus_byte(8'h0C, ack); exp_en = apply_byte(exp_en, 0, 8'h0C);
        bus_stop();
        check_outs("R10 repeated start");

        // R2: read request is not acknowledged
        bus_start();
        bus_byte({ADDR, 1'b1}, ack); chk("R2 read no ack", {31'd0, ack}, 32'd0);
        bus_byte(8'hFF, ack); chk("R2 read data no ack", {31'd0, ack}, 32'd0);
        bus_stop();
        check_outs("R2 read ignored");

        // R8: global disable
        set_oe(1'b0);
        check_outs("R8 oe low");
        set_oe(1'b1);
        check_outs("R8 oe high");

        // Random mix of good, mismatched and read transfers
        for (int t = 0; t < 40; t++) begin
            kind = int'($urandom % 8);
            nb = 1 + int'($urandom % 5);
            bus_start();
            if (kind == 0) begin
                a = 7'($urandom);
                if (a == ADDR) a = a ^ 7'h01;
                bus_byte({a, 1'b0}, ack); chk("R2 mismatch no ack", {31'd0, ack}, 32'd0);
            end else if (kind == 1) begin
                bus_byte({ADDR, 1'b1}, ack); chk("R2 read no ack", {31'd0, ack}, 32'd0);
            end else begin
                bus_byte({ADDR, 1'b0}, ack); chk("R1 address ack", {31'd0, ack}, 32'd1);
            end
            for (int k = 0; k < nb; k++) begin
                d = 8'($urandom);
                bus_byte(d, ack);
                if (kind > 1) begin
                    chk("R3 data ack", {31'd0, ack}, 32'd1);
                    exp_en = apply_byte(exp_en, k, d);
                end else begin
                    chk("R2 data no ack", {31'd0, ack}, 32'd0);
                end
            end
            bus_stop();
            chk("R11 release after stop", {31'd0, sda_pull}, 32'd0);
            set_oe(($urandom % 5) != 0);
            check_outs("R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_in);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule